// File: doc/BRIEF.md
# Host Bus Slave Port with Register File and Data Queues

This block lets a host processor reach a small register file and two data queues through an asynchronous bus modelled on static memory. The host drives an active-low select, an active-low read strobe, an active-low write strobe, a halfword address (address bits 7 down to 1), a data bus and a queue-select line. The port never answers with a ready or wait signal. The host spaces its own cycles with programmed wait states, so read data appears a fixed number of core clocks after the strobe or after an address change.

The strobes, the address and the queue select are brought into the core clock through two flip-flop stages. A read access is counted once when the strobe is first seen and again on every address change while the strobes stay low. This gives bursts with toggled addresses. When queue-select is high, address bits 7..3 are ignored. Reads then drain the receive queue and writes fill the transmit queue. A DMA engine that keeps incrementing the address therefore stays on the data path. The bus width, 32 or 16 bits, is taken from a strap input when reset ends. In the 16-bit width, a configuration bit picks the halfword order.

The core side of the queues uses valid/ready streams. A receive word is taken only while `rx_in_ready` is high. A transmit word leaves only on a cycle where both `tx_out_valid` and `tx_out_ready` are high. While a word is offered and not taken, it stays unchanged.

Top module: `hostbus_slave`

## Requirements
- R1: `bus_wide` holds the value of `strap_wide` sampled at the end of reset (1 = 32-bit bus, 0 = 16-bit bus) and does not change until the next reset.
- R2: Word address = address bits [7:2]. Words 8..11 are read/write scratch registers. Reads of an unmapped word return 0, and writes to it change nothing. Read data appears on `bus_rdata` within 3 clock cycles of the strobe or address change and holds until the next read access.
- R3: With queue-select low, words 0..7 form the data window: a read takes the next receive word and a write adds a transmit word.
- R4: With queue-select high, address bits [7:3] are ignored: every read takes from the receive queue and every write adds to the transmit queue.
- R5: One access takes exactly one receive entry. A new entry is taken on strobe assertion and on each change of the address while the strobes stay low (only address bits [2:1] count when queue-select is high). A held strobe takes nothing more.
- R6: A read from the empty receive queue returns 0 and sets the sticky `rx_underrun` flag.
- R7: A write to the full transmit queue is dropped and sets the sticky `tx_overrun` flag.
- R8: In 16-bit mode, data uses bus bits [15:0] and `bus_rdata[31:16]` reads 0. Word 16 bit 0 is the order bit: 0 = address bit 1 low selects the lower half, 1 = the selection is swapped.
- R9: In 16-bit mode, each queue word moves as two halfword accesses: lower half first when the order bit is 0, upper half first when it is 1. A receive word is taken after both halves are read, and a transmit word is added after both halves are written.
- R10: `rx_in_ready` is low while the receive queue holds 8 words. `tx_out_valid` is high while the transmit queue holds data, and its word is stable until it is taken.
- R11: After reset, `bus_rdata` is 0, both flags are clear, both queues are empty and the order bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| strap_wide | input | 1 | Bus width strap, sampled at end of reset |
| bus_cs_n | input | 1 | Active-low select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 7 | Halfword address, bits 7..1 |
| bus_fifo_sel | input | 1 | Queue select, overrides decoding |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_wide | output | 1 | Latched width, 1 = 32-bit |
| rx_in_valid | input | 1 | Receive stream word offered |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 32 | Receive stream word |
| tx_out_valid | output | 1 | Transmit word offered |
| tx_out_ready | input | 1 | Transmit word taken |
| tx_out_data | output | 32 | Transmit word |
| rx_underrun | output | 1 | Sticky empty-read flag |
| tx_overrun | output | 1 | Sticky dropped-write flag |

## Verification
A fault in the access-event logic shows up as shifted receive data. If it takes an extra entry while a strobe is held, or misses one on an address change, the next read returns a word from the wrong position. This is visible within a few clocks, at the next sampling point of a burst. A wrong halfword counter or order bit shows on the first 16-bit queue access as swapped or repeated halves, or as a transmit word that appears after only one halfword write. Errors in the flags or the full/empty logic appear at the access that reaches the boundary, through `rx_underrun`, `tx_overrun`, `rx_in_ready` or `tx_out_valid`.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int DW     = 32;
  localparam int HW     = DW / 2;
  localparam int ADR_W  = 7;          // halfword address bits
  localparam int WRD_W  = ADR_W - 1;  // word address bits
  typedef enum logic [1:0] {TGT_NONE, TGT_FIFO, TGT_REG, TGT_CFG} tgt_e;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int            W   = 1,
  parameter logic [W-1:0]  RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/hbs_fifo.sv
module hbs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign head  = mem[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/hbs_regs.sv
module hbs_regs #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int IW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_half,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int HW = DW / 2;

  logic [DW-1:0] flat [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val <= '0;
      end else if (wr_en && wr_idx == IW'(r)) begin
        if (wr_half[0]) val[HW-1:0]  <= wr_data[HW-1:0];
        if (wr_half[1]) val[DW-1:HW] <= wr_data[DW-1:HW];
      end
    end
    assign flat[r] = val;
  end

  assign rd_data = flat[rd_idx];
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hbs_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int NREG       = 4   // at most 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_wide,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [6:0]    bus_addr,
  input  logic          bus_fifo_sel,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_wide,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [31:0]   rx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [31:0]   tx_out_data,
  output logic          rx_underrun,
  output logic          tx_overrun
);
  localparam int WIN_WORDS = 8;
  localparam int REG_BASE  = WIN_WORDS;
  localparam int CFG_WORD  = 2 * WIN_WORDS;
  localparam int IW        = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SW        = 4 + ADR_W;
  localparam logic [WRD_W-1:0] WIN_END = WRD_W'(WIN_WORDS);
  localparam logic [WRD_W-1:0] REG_LO  = WRD_W'(REG_BASE);
  localparam logic [WRD_W-1:0] REG_HI  = WRD_W'(REG_BASE + NREG);
  localparam logic [WRD_W-1:0] CFG_A   = WRD_W'(CFG_WORD);

  // ---------------- strobe / address synchronisation ----------------
  logic [SW-1:0]    sync_q;
  logic             cs_s, rd_s, wr_s, fs_s;
  logic [ADR_W-1:0] ad_s, ad_q;

  hbs_sync #(.W(SW), .RST({3'b111, 1'b0, {ADR_W{1'b0}}})) u_sync (
    .clk (clk), .rst_n (rst_n),
    .d   ({bus_cs_n, bus_rd_n, bus_wr_n, bus_fifo_sel, bus_addr}),
    .q   (sync_q)
  );
  assign {cs_s, rd_s, wr_s, fs_s, ad_s} = sync_q;

  logic rd_act, wr_act, rd_act_q, wr_act_q, addr_moved, rd_ev, wr_ev;
  assign rd_act     = !cs_s && !rd_s;
  assign wr_act     = !cs_s && !wr_s;
  assign addr_moved = fs_s ? (ad_s[1:0] != ad_q[1:0]) : (ad_s != ad_q);
  assign rd_ev      = rd_act && (!rd_act_q || addr_moved);   // R5
  assign wr_ev      = wr_act && !wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
      ad_q     <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      ad_q     <= ad_s;
    end
  end

  // ---------------- width strap (R1) ----------------
  logic wide_q;
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= strap_wide;
  end
  assign bus_wide = wide_q;

  // ---------------- decode ----------------
  logic [WRD_W-1:0] word;
  logic             a1;
  tgt_e             tgt;
  assign word = ad_s[ADR_W-1:1];
  assign a1   = ad_s[0];

  always_comb begin
    if (fs_s || word < WIN_END)             tgt = TGT_FIFO;  // R3 R4
    else if (word >= REG_LO && word < REG_HI) tgt = TGT_REG;
    else if (word == CFG_A)                 tgt = TGT_CFG;
    else                                    tgt = TGT_NONE;
  end

  // ---------------- state ----------------
  logic          be_q, rx_hc, tx_hc, und_q, ovr_q;
  logic [DW-1:0] tx_hold, rdata_q;

  // ---------------- queues ----------------
  logic          rx_empty, rx_full, rx_pop;
  logic [DW-1:0] rx_head;
  logic          tx_empty, tx_full, tx_push;
  logic [DW-1:0] tx_push_data;

  hbs_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk (clk), .rst_n (rst_n),
    .push (rx_in_valid), .push_data (rx_in_data),
    .pop (rx_pop), .head (rx_head), .empty (rx_empty), .full (rx_full)
  );

  hbs_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk (clk), .rst_n (rst_n),
    .push (tx_push), .push_data (tx_push_data),
    .pop (tx_out_ready), .head (tx_out_data), .empty (tx_empty), .full (tx_full)
  );

  assign rx_in_ready  = !rx_full;
  assign tx_out_valid = !tx_empty;

  // ---------------- register file ----------------
  logic [IW-1:0] reg_idx;
  logic [DW-1:0] reg_rd, reg_wdata;
  logic [1:0]    reg_half;
  logic [HW-1:0] whalf;
  logic          wsel_up;

  assign reg_idx   = IW'(word - REG_LO);
  assign whalf     = bus_wdata[HW-1:0];
  assign wsel_up   = (tgt == TGT_FIFO) ? (tx_hc ^ be_q) : (a1 ^ be_q);
  assign reg_wdata = wide_q ? bus_wdata : {whalf, whalf};
  assign reg_half  = wide_q ? 2'b11 : (wsel_up ? 2'b10 : 2'b01);

  hbs_regs #(.NREG(NREG), .DW(DW), .IW(IW)) u_regs (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_ev && tgt == TGT_REG), .wr_idx (reg_idx),
    .wr_data (reg_wdata), .wr_half (reg_half),
    .rd_idx (reg_idx), .rd_data (reg_rd)
  );

  // ---------------- read path ----------------
  logic [DW-1:0] rd_word, rd_bus;
  logic          hsel, rx_take, und_set;

  always_comb begin
    unique case (tgt)
      TGT_FIFO: rd_word = rx_empty ? '0 : rx_head;
      TGT_REG:  rd_word = reg_rd;
      TGT_CFG:  rd_word = {{(DW-1){1'b0}}, be_q};
      default:  rd_word = '0;
    endcase
  end

  assign hsel    = (tgt == TGT_FIFO) ? (rx_hc ^ be_q) : (a1 ^ be_q);   // R8 R9
  assign rd_bus  = wide_q ? rd_word
                          : {{HW{1'b0}}, hsel ? rd_word[DW-1:HW] : rd_word[HW-1:0]};
  assign rx_take = rd_ev && tgt == TGT_FIFO && !rx_empty;
  assign rx_pop  = rx_take && (wide_q || rx_hc);
  assign und_set = rd_ev && tgt == TGT_FIFO && rx_empty;                // R6

  // ---------------- write path ----------------
  logic tx_wr;
  assign tx_wr        = wr_ev && tgt == TGT_FIFO;
  assign tx_push      = tx_wr && !tx_full && (wide_q || tx_hc);
  assign tx_push_data = wide_q  ? bus_wdata
                      : wsel_up ? {whalf, tx_hold[HW-1:0]}
                                : {tx_hold[DW-1:HW], whalf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      be_q    <= 1'b0;
      rx_hc   <= 1'b0;
      tx_hc   <= 1'b0;
      tx_hold <= '0;
      und_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd_ev) rdata_q <= rd_bus;
      if (rx_take && !wide_q) rx_hc <= !rx_hc;
      if (und_set) und_q <= 1'b1;
      if (tx_wr && tx_full && (wide_q || tx_hc)) ovr_q <= 1'b1;         // R7
      if (tx_wr && !wide_q) begin
        tx_hc <= !tx_hc;
        if (!tx_hc) begin
          if (wsel_up) tx_hold[DW-1:HW] <= whalf;
          else         tx_hold[HW-1:0]  <= whalf;
        end
      end
      if (wr_ev && tgt == TGT_CFG) begin
        if (wide_q)        be_q <= bus_wdata[0];
        else if (!wsel_up) be_q <= whalf[0];
      end
    end
  end

  assign bus_rdata   = rdata_q;
  assign rx_underrun = und_q;
  assign tx_overrun  = ovr_q;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_ev,
  input logic [31:0] bus_rdata,
  input logic        bus_wide,
  input logic        rx_underrun,
  input logic        tx_overrun,
  input logic        tx_out_valid,
  input logic        tx_out_ready,
  input logic [31:0] tx_out_data
);
  AST_WIDTH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(bus_wide)); // R1

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(bus_rdata)); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wide |-> bus_rdata[31:16] == 16'h0); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun |=> rx_underrun); // R6

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> tx_overrun); // R7

  AST_TX_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data)); // R10
endmodule

bind hostbus_slave hbs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_ev        (rd_ev),
  .bus_rdata    (bus_rdata),
  .bus_wide     (bus_wide),
  .rx_underrun  (rx_underrun),
  .tx_overrun   (tx_overrun),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_data  (tx_out_data)
);

// File: tb/sim_hostbus_slave.sv
`timescale 1ns/1ps
module sim_hostbus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_wide = 1'b1;
  logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic        bus_fifo_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wide;
  logic        rx_in_valid = 1'b0;
  logic        rx_in_ready;
  logic [31:0] rx_in_data = '0;
  logic        tx_out_valid;
  logic        tx_out_ready = 1'b0;
  logic [31:0] tx_out_data;
  logic        rx_underrun, tx_overrun;

  always #2 clk = ~clk;   // 250 MHz

  hostbus_slave u0 (.*);

  int n_run = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n = 1'b0; strap_wide = wide;
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    rx_in_valid = 1'b0; tx_out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_wr(input logic fs, input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_fifo_sel = fs; bus_addr = a; bus_wdata = d;
    bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_rd(input logic fs, input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_fifo_sel = fs; bus_addr = a;
    bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    repeat (3) @(negedge clk);   // R2 latency bound
    d = bus_rdata;
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_put(input logic [31:0] d);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [31:0] d);
    @(negedge clk);
    v = tx_out_valid; d = tx_out_data;
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // op codes: 0 write, 1 read, 2 receive inject, 3 transmit check
  localparam int NV = 19;
  localparam logic [77:0] VEC [NV] = '{
    {2'd0, 1'b0, 7'h10, 32'hA5A5_0001, 32'h0,          4'd2},  // R2 reg0
    {2'd0, 1'b0, 7'h16, 32'h1234_5678, 32'h0,          4'd2},  // R2 reg3
    {2'd1, 1'b0, 7'h10, 32'h0,         32'hA5A5_0001, 4'd2},
    {2'd1, 1'b0, 7'h16, 32'h0,         32'h1234_5678, 4'd2},
    {2'd2, 1'b0, 7'h00, 32'h1111_0001, 32'h0,          4'd3},
    {2'd2, 1'b0, 7'h00, 32'h2222_0002, 32'h0,          4'd3},
    {2'd1, 1'b0, 7'h00, 32'h0,         32'h1111_0001, 4'd3},  // R3 window read
    {2'd1, 1'b1, 7'h7C, 32'h0,         32'h2222_0002, 4'd4},  // R4 upper bits ignored
    {2'd0, 1'b1, 7'h3E, 32'hCAFE_0003, 32'h0,          4'd4},
    {2'd0, 1'b0, 7'h0E, 32'hBEEF_0004, 32'h0,          4'd3},
    {2'd3, 1'b0, 7'h00, 32'h0,         32'hCAFE_0003, 4'd4},
    {2'd3, 1'b0, 7'h00, 32'h0,         32'hBEEF_0004, 4'd3},
    {2'd1, 1'b0, 7'h40, 32'h0,         32'h0,          4'd2},  // unmapped read
    {2'd0, 1'b0, 7'h40, 32'hFFFF_FFFF, 32'h0,          4'd2},
    {2'd1, 1'b0, 7'h10, 32'h0,         32'hA5A5_0001, 4'd2},
    {2'd1, 1'b0, 7'h7C, 32'h0,         32'h0,          4'd2},
    {2'd0, 1'b0, 7'h20, 32'h0000_0001, 32'h0,          4'd8},  // R8 order bit
    {2'd1, 1'b0, 7'h20, 32'h0,         32'h0000_0001, 4'd8},
    {2'd0, 1'b0, 7'h20, 32'h0,         32'h0,          4'd8}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    report();
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic        v;

    // R11 R1 reset state, wide strap
    do_reset(1'b1);
    chk("R11 rdata", bus_rdata, 32'h0);
    chk("R11 underrun", {31'b0, rx_underrun}, 32'h0);
    chk("R11 overrun", {31'b0, tx_overrun}, 32'h0);
    chk("R11 tx empty", {31'b0, tx_out_valid}, 32'h0);
    chk("R10 rx ready", {31'b0, rx_in_ready}, 32'h1);
    chk("R1 wide", {31'b0, bus_wide}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] e;
      e = VEC[i];
      case (e[77:76])
        2'd0: bus_wr(e[75], e[74:68], e[67:36]);
        2'd1: begin
          bus_rd(e[75], e[74:68], d);
          chk($sformatf("R%0d vec %0d read", e[3:0], i), d, e[35:4]);
        end
        2'd2: rx_put(e[67:36]);
        default: begin
          tx_take(v, d);
          chk($sformatf("R%0d vec %0d tx valid", e[3:0], i), {31'b0, v}, 32'h1);
          chk($sformatf("R%0d vec %0d tx data", e[3:0], i), d, e[35:4]);
        end
      endcase
    end

    // R10 receive back-pressure, R5 burst with toggled address
    for (int i = 0; i < 8; i++) rx_put(32'hB000_0000 + i);
    @(negedge clk);
    chk("R10 rx full", {31'b0, rx_in_ready}, 32'h0);
    bus_fifo_sel = 1'b1; bus_addr = 7'h00;
    bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin
        @(negedge clk);
        bus_addr = {5'(i * 3), 2'(i)};
      end
      repeat (3) @(negedge clk);
      if (i == 3) repeat (10) @(negedge clk);   // R5 held strobe takes nothing more
      chk($sformatf("R5 burst %0d", i), bus_rdata, 32'hB000_0000 + i);
    end
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 rx room again", {31'b0, rx_in_ready}, 32'h1);

    // R6 underrun
    bus_rd(1'b1, 7'h00, d);
    chk("R6 empty read data", d, 32'h0);
    chk("R6 flag set", {31'b0, rx_underrun}, 32'h1);
    bus_wr(1'b0, 7'h10, 32'h5);
    chk("R6 flag sticky", {31'b0, rx_underrun}, 32'h1);

    // R7 overrun
    for (int i = 0; i < 8; i++) bus_wr(1'b1, 7'h00, 32'hC000_0000 + i);
    chk("R7 no flag at full", {31'b0, tx_overrun}, 32'h0);
    bus_wr(1'b1, 7'h00, 32'hDEAD_BEEF);
    chk("R7 flag set", {31'b0, tx_overrun}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      tx_take(v, d);
      chk($sformatf("R7 drain %0d", i), d, 32'hC000_0000 + i);
    end
    @(negedge clk);
    chk("R7 dropped word absent", {31'b0, tx_out_valid}, 32'h0);
    chk("R7 flag sticky", {31'b0, tx_overrun}, 32'h1);

    // 16-bit mode
    do_reset(1'b0);
    chk("R1 narrow strap", {31'b0, bus_wide}, 32'h0);
    chk("R11 flags cleared", {30'b0, rx_underrun, tx_overrun}, 32'h0);
    bus_wr(1'b0, 7'h10, 32'h0000_1111);
    bus_wr(1'b0, 7'h11, 32'hFFFF_2222);
    bus_rd(1'b0, 7'h10, d);
    chk("R8 low half", d, 32'h0000_1111);
    bus_rd(1'b0, 7'h11, d);
    chk("R8 high half", d, 32'h0000_2222);
    // R9 little-endian queue order (order bit 0 after reset, R11)
    rx_put(32'h1357_2468);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 LE first half", d, 32'h0000_2468);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 LE second half", d, 32'h0000_1357);
    // set order bit
    bus_wr(1'b0, 7'h20, 32'h0000_0001);
    bus_rd(1'b0, 7'h21, d);
    chk("R8 order bit readback", d, 32'h0000_0001);
    bus_rd(1'b0, 7'h10, d);
    chk("R8 swapped half", d, 32'h0000_2222);
    // R9 big-endian, take only after both halves
    rx_put(32'hAAAA_BBBB);
    rx_put(32'hCCCC_DDDD);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 BE half 1", d, 32'h0000_AAAA);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 BE half 2", d, 32'h0000_BBBB);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 BE half 3", d, 32'h0000_CCCC);
    bus_rd(1'b1, 7'h00, d);
    chk("R9 BE half 4", d, 32'h0000_DDDD);
    bus_rd(1'b1, 7'h00, d);
    chk("R6 narrow empty", d, 32'h0);
    chk("R6 narrow flag", {31'b0, rx_underrun}, 32'h1);
    bus_wr(1'b1, 7'h00, 32'h0000_1234);
    chk("R9 no push after one half", {31'b0, tx_out_valid}, 32'h0);
    bus_wr(1'b1, 7'h00, 32'h0000_5678);
    tx_take(v, d);
    chk("R9 tx valid", {31'b0, v}, 32'h1);
    chk("R9 tx word", d, 32'h1234_5678);

    report();
    $finish;
  end
endmodule